// File: doc/BRIEF.md
# Sleep-State Standby Wake Timer

This block watches a light sleep state and wakes the system after a programmed delay. When a sleep-entry pulse arrives it captures a 4-bit tick count and a one-bit rate select, then counts coarse ticks derived from a free-running base time strobe. When the programmed number of coarse ticks has gone by, it raises a one-cycle wake pulse and goes idle until the next entry.

A prescaler divides the base strobe by 2^SHORT_EXP (rate select 0) or 2^LONG_EXP (rate select 1). With the default exponents of 16 and 21 and a one-millisecond strobe, the two coarse ticks last 65.536 s and 2097.152 s, a ratio of 32. A count of zero leaves the timer inert. A sleep-exit pulse stops a run in progress without producing a wake. Both exponents are parameters so that a test can use short periods.

Top module: `stby_wake_timer`

## Requirements
- R1: After reset, wake_pulse is low and no wake happens until a sleep entry with a nonzero count.
- R2: With rate select 0 and count N (1..15) captured at entry, wake_pulse rises one cycle after the clock edge that samples the N*2^SHORT_EXP-th base strobe counted after the entry edge. A strobe in the same cycle as the entry is not counted.
- R3: With rate select 1 and count N, the wake follows N*2^LONG_EXP counted base strobes, which is 2^(LONG_EXP-SHORT_EXP) times the delay for select 0.
- R4: An entry with a count of 0 never produces a wake.
- R5: wake_pulse is high for exactly one cycle. After it, no further wake occurs without a new entry.
- R6: A sleep-exit pulse ends a run with no wake. The next entry starts counting again from its full delay.
- R7: The count and rate select are sampled only at entry. Changes made while counting do not alter the delay.
- R8: If a sleep-exit pulse falls in the same cycle as the final base strobe of a run, there is no wake.
- R9: An entry during a run restarts it with the newly captured values. This includes an entry in the same cycle as the final strobe, where the old run gives no wake.
- R10: Base strobes that arrive while the timer is idle have no effect on a later run's delay.
- R11: If sleep entry and sleep exit are high in the same cycle, exit wins and the timer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base time strobe, one cycle per base period |
| tick_count | input | 4 | Number of coarse ticks to wait, 0 disables |
| rate_sel | input | 1 | 0 = short coarse tick, 1 = long coarse tick |
| sleep_enter | input | 1 | One-cycle pulse on entry to light sleep |
| sleep_exit | input | 1 | One-cycle pulse on leaving light sleep |
| wake_pulse | output | 1 | One-cycle wake event on expiry |

## Verification
The expiring base strobe can coincide with either a sleep-exit pulse or a fresh sleep-entry pulse. The bench counts strobes up to one short of expiry, then drives the final strobe in the same cycle as exit, and in a separate test in the same cycle as a new entry. Exit must suppress the wake permanently. Re-entry must suppress the old wake and then produce exactly one wake after the new run's full strobe count. Simultaneous entry and exit are judged the same way: no wake across a long strobe window.

// File: rtl/swt_pkg.sv
package swt_pkg;
    typedef enum logic {
        RATE_SHORT = 1'b0,
        RATE_LONG  = 1'b1
    } rate_e;
endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler
    import swt_pkg::*;
#(
    parameter int SHORT_EXP = 16,
    parameter int LONG_EXP  = 21
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  run,
    input  logic  base_tick,
    input  rate_e rate,
    output logic  tick_o
);
    localparam int W = LONG_EXP;
    localparam logic [W-1:0] LONG_MASK  = {W{1'b1}};
    localparam logic [W-1:0] SHORT_MASK = LONG_MASK >> (LONG_EXP - SHORT_EXP);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t      st_d, st_q;
    logic [W-1:0] wrap_at;
    logic         step;

    always_comb begin
        wrap_at = (rate == RATE_LONG) ? LONG_MASK : SHORT_MASK;
        step    = run && !clr && base_tick;
        tick_o  = step && (st_q.cnt == wrap_at);
        st_d    = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = tick_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the divider never runs past the selected period
    p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= wrap_at);
    // R10: while not running, strobes leave the divider untouched
    p_presc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(st_q.cnt));
endmodule

// File: rtl/swt_tick_counter.sv
module swt_tick_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             coarse_tick,
    output logic             armed_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        armed_o  = (st_q.left != '0);
        expire_o = coarse_tick && (st_q.left == ONE) && !clr && !load;
        st_d     = st_q;
        if (clr) begin
            st_d.left = '0;
        end else if (load) begin
            st_d.left = load_val;
        end else if (coarse_tick && armed_o) begin
            st_d.left = st_q.left - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: remaining count moves only on a load, a clear or a coarse tick
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !coarse_tick) |=> $stable(st_q.left));
    // R5: expiry leaves the counter idle
    p_expire_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (st_q.left == '0));
endmodule

// File: rtl/stby_wake_timer.sv
module stby_wake_timer
    import swt_pkg::*;
#(
    parameter int SHORT_EXP = 16,
    parameter int LONG_EXP  = 21,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic [CNT_W-1:0] tick_count,
    input  logic             rate_sel,
    input  logic             sleep_enter,
    input  logic             sleep_exit,
    output logic             wake_pulse
);
    typedef struct packed {
        rate_e rate;
        logic  wake;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    load, pre_clr, armed, coarse, expire;

    assign load    = sleep_enter && !sleep_exit;
    assign pre_clr = sleep_enter || sleep_exit;

    swt_prescaler #(.SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pre_clr),
        .run       (armed),
        .base_tick (base_tick),
        .rate      (st_q.rate),
        .tick_o    (coarse)
    );

    swt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (sleep_exit),
        .load        (load),
        .load_val    (tick_count),
        .coarse_tick (coarse),
        .armed_o     (armed),
        .expire_o    (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = expire;
        if (load) st_d.rate = rate_e'(rate_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rate: RATE_SHORT, wake: 1'b0};
        else        st_q <= st_d;
    end

    assign wake_pulse = st_q.wake;

    // R5: single-cycle wake, then idle
    p_wake_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    p_wake_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !armed);
    // R6: exit never lets a wake through
    p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_exit |=> (!wake_pulse && !armed));
    // R4: zero-count entry leaves the timer disarmed
    p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick_count == '0) |=> !armed);
endmodule

// File: tb/stby_wake_timer_test.sv
module stby_wake_timer_test;
    localparam int SE = 2;
    localparam int LE = 7;
    localparam int NV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic [3:0] tick_count = '0;
    logic       rate_sel = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       sleep_exit = 1'b0;
    logic       wake_pulse;

    int checks = 0;
    int errors = 0;
    logic seen;

    always #2 clk = ~clk;

    stby_wake_timer #(.SHORT_EXP(SE), .LONG_EXP(LE), .CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .tick_count(tick_count),
        .rate_sel(rate_sel), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
        .wake_pulse(wake_pulse)
    );

    // {count, rate, strobe spacing in cycles, expected strobes (0 = none)}
    typedef struct packed {
        logic [3:0] cnt;
        logic       rate;
        logic [3:0] gap;
        logic [15:0] exp_n;
    } vec_t;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, 4'd1, 16'(1  << SE)},
        '{4'd5,  1'b0, 4'd1, 16'(5  << SE)},
        '{4'd15, 1'b0, 4'd3, 16'(15 << SE)},
        '{4'd9,  1'b0, 4'd2, 16'(9  << SE)},
        '{4'd1,  1'b1, 4'd1, 16'(1  << LE)},
        '{4'd3,  1'b1, 4'd2, 16'(3  << LE)},
        '{4'd15, 1'b1, 4'd1, 16'(15 << LE)},
        '{4'd0,  1'b0, 4'd1, 16'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one negedge: sample result of previous edge, then drive inputs
    task automatic step(input bit en, input bit ex, input bit tk);
        @(negedge clk);
        seen        = wake_pulse;
        sleep_enter = en;
        sleep_exit  = ex;
        base_tick   = tk;
    endtask

    task automatic enter(input logic [3:0] c, input logic r);
        tick_count = c;
        rate_sel   = r;
        step(1'b1, 1'b0, 1'b0);
    endtask

    // drive n strobes; report strobe index at first wake and wake cycles
    task automatic strobes(input int n, input int gap, output int first, output int wakes);
        int sent = 0;
        int cyc  = 0;
        first = 0;
        wakes = 0;
        while (sent < n || cyc % gap != 0 || cyc == 0) begin
            bit tk = (cyc % gap == 0) && (sent < n);
            step(1'b0, 1'b0, tk);
            if (seen) begin
                wakes++;
                if (first == 0) first = sent;
            end
            if (tk) sent++;
            cyc++;
        end
        for (int i = 0; i < 2; i++) begin
            step(1'b0, 1'b0, 1'b0);
            if (seen) begin
                wakes++;
                if (first == 0) first = sent;
            end
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int f, w;
        repeat (3) @(negedge clk);
        check(wake_pulse == 1'b0, "R1", wake_pulse, 0);
        rst_n = 1'b1;
        strobes(40, 1, f, w);
        check(w == 0, "R1", w, 0);

        for (int k = 0; k < NV; k++) begin
            enter(VECS[k].cnt, VECS[k].rate);
            strobes(VECS[k].exp_n == 0 ? 200 : int'(VECS[k].exp_n) + 20, int'(VECS[k].gap), f, w);
            if (VECS[k].exp_n == 0) begin
                check(w == 0, "R4", w, 0);
            end else begin
                check(f == int'(VECS[k].exp_n), VECS[k].rate ? "R3" : "R2", f, int'(VECS[k].exp_n));
                check(w == 1, "R5", w, 1);
            end
        end

        // R5: no second wake after expiry
        strobes(100, 1, f, w);
        check(w == 0, "R5", w, 0);

        // R6: exit mid-run, then full restart
        enter(4'd2, 1'b0);
        strobes(5, 1, f, w);
        step(1'b0, 1'b1, 1'b0);
        strobes(30, 1, f, w);
        check(w == 0, "R6", w, 0);
        enter(4'd2, 1'b0);
        strobes(20, 1, f, w);
        check(f == (2 << SE), "R6", f, 2 << SE);

        // R7: config changes while counting are ignored
        enter(4'd3, 1'b0);
        strobes(2, 1, f, w);
        tick_count = 4'd1;
        rate_sel   = 1'b1;
        strobes(20, 1, f, w);
        check(f + 2 == (3 << SE), "R7", f + 2, 3 << SE);

        // R8: exit with the final strobe
        enter(4'd1, 1'b0);
        strobes((1 << SE) - 1, 1, f, w);
        step(1'b0, 1'b1, 1'b1);
        strobes(40, 1, f, w);
        check(w == 0, "R8", w, 0);

        // R9: re-entry mid-run restarts with new values
        enter(4'd4, 1'b0);
        strobes(10, 1, f, w);
        enter(4'd1, 1'b1);
        strobes((1 << LE) + 10, 1, f, w);
        check(f == (1 << LE), "R9", f, 1 << LE);
        // R9: re-entry on the final strobe suppresses old wake
        enter(4'd1, 1'b0);
        strobes((1 << SE) - 1, 1, f, w);
        tick_count = 4'd2;
        rate_sel   = 1'b0;
        step(1'b1, 1'b0, 1'b1);
        strobes(30, 1, f, w);
        check(f == (2 << SE), "R9", f, 2 << SE);
        check(w == 1, "R9", w, 1);

        // R10: idle strobes do not shorten a later run
        strobes(7, 1, f, w);
        enter(4'd3, 1'b0);
        strobes(30, 1, f, w);
        check(f == (3 << SE), "R10", f, 3 << SE);

        // R11: simultaneous entry and exit
        tick_count = 4'd2;
        step(1'b1, 1'b1, 1'b0);
        strobes(60, 1, f, w);
        check(w == 0, "R11", w, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule